// File: doc/BRIEF.md
# Banked Level Interrupt Aggregator

This block gathers 72 level-sensitive interrupt sources into a single request line for a processor and presents their state through a small word-wide register port. The sources are split into three groups. A local group holds 8 sources and has flat numbers 0 to 7. The first bank holds 32 sources, numbered 8 to 39 (bank bit plus 8). The second bank holds 32 sources, numbered 40 to 71 (bank bit plus 40).

Each source has one enable bit. Software can change an enable bit only through a write-one-to-set register and a write-one-to-clear register for that group. A source counts as pending while its raw input is high and its enable bit is set. The pending state is not latched: it follows the input level.

Software reads two bank pending words and one summary word. The summary word gives quick access to the local sources and to eleven selected bank sources. It also holds one flag per bank that reports any other pending source in that bank. A stored control word for fast-interrupt routing can be written and read back.

Top module: `ictl_top`

## Requirements
- R1: Reset is synchronous and active high. It clears every enable bit, the fast-interrupt control word, `irq_o` and `rdata`.
- R2: A write to a set address (0x18 local, 0x10 bank 1, 0x14 bank 2) sets the enable of each source whose data bit is 1. Enables whose data bit is 0 are unchanged.
- R3: A write to a clear address (0x24 local, 0x1C bank 1, 0x20 bank 2) clears the enable of each source whose data bit is 1. Enables whose data bit is 0 are unchanged.
- R4: Bit n of the bank pending words (0x04 bank 1, 0x08 bank 2) reads 1 exactly when bank source n has its input high and is enabled. The value follows the input level and is not latched.
- R5: Bits 0 to 7 of the summary word (0x00) are the pending states of local sources 0 to 7.
- R6: Summary bits 10 to 14 copy the pending states of bank-1 sources 7, 9, 10, 18 and 19, in that order. Summary bits 15 to 20 copy the pending states of bank-2 sources 21, 22, 23, 24, 25 and 30, in that order.
- R7: Summary bit 8 (for bank 1) and summary bit 9 (for bank 2) are 1 only when that bank has a pending source that is not one of the sources copied under R6.
- R8: Summary bits 21 to 31 always read 0.
- R9: A read of any set or clear address returns the current enable mask of that group. The local mask is zero-extended.
- R10: `irq_o` is the OR of all 72 pending states. It is registered, so it follows one clock after the inputs or enables change.
- R11: The fast-interrupt control word (0x0C) reads back the last value written to it. Writes to the pending addresses and the summary address change no enable bit.
- R12: `rdata` is registered. It shows the register selected by `addr` at the previous rising edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address of the register |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src_i | input | 72 | Raw source levels, indexed by flat source number |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest case to set up is telling a shortcut source apart from a plain source of the same bank. A bank flag must stay low while the only pending sources in that bank are copied ones. It must rise as soon as any other source in that bank becomes pending.

The bench covers this in two sweeps. In the first, every source is enabled and each of the 72 flat sources is raised alone. The bench then compares the full summary, both bank words and the request line against values computed from the bit lists. In the second sweep, each enable is cleared in turn while its source stays high. Pseudo-random mixes of source levels and set/clear writes then exercise several pending sources at once.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  localparam int LOCAL_N = 8;
  localparam int BANK_N  = 32;
  localparam int N_GRP   = 3;
  localparam int N_SRC   = LOCAL_N + 2 * BANK_N;

  // register byte offsets
  localparam int OFS_SUM   = 'h00;
  localparam int OFS_P1    = 'h04;
  localparam int OFS_P2    = 'h08;
  localparam int OFS_FCTL  = 'h0C;
  localparam int OFS_SET1  = 'h10;
  localparam int OFS_SET2  = 'h14;
  localparam int OFS_SETL  = 'h18;
  localparam int OFS_CLR1  = 'h1C;
  localparam int OFS_CLR2  = 'h20;
  localparam int OFS_CLRL  = 'h24;

  // summary layout
  localparam int SC1_N     = 5;
  localparam int SC2_N     = 6;
  localparam int FLAG1_BIT = LOCAL_N;
  localparam int FLAG2_BIT = LOCAL_N + 1;
  localparam int SC1_BASE  = LOCAL_N + 2;
  localparam int SC2_BASE  = SC1_BASE + SC1_N;
  localparam int SUM_USED  = SC2_BASE + SC2_N;

  localparam int SC1_IDX [SC1_N] = '{7, 9, 10, 18, 19};
  localparam int SC2_IDX [SC2_N] = '{21, 22, 23, 24, 25, 30};

  // group 0 is the local group, 1 and 2 are the banks
  function automatic int grp_lo(input int g);
    return (g == 0) ? 0 : LOCAL_N + (g - 1) * BANK_N;
  endfunction

  function automatic int grp_w(input int g);
    return (g == 0) ? LOCAL_N : BANK_N;
  endfunction

  function automatic logic [BANK_N-1:0] sc1_mask();
    logic [BANK_N-1:0] m;
    m = '0;
    for (int i = 0; i < SC1_N; i++) m[SC1_IDX[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [BANK_N-1:0] sc2_mask();
    logic [BANK_N-1:0] m;
    m = '0;
    for (int i = 0; i < SC2_N; i++) m[SC2_IDX[i]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ictl_enable_grp.sv
module ictl_enable_grp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] en_o
);
  logic [W-1:0] set_m;
  logic [W-1:0] clr_m;

  always_comb begin
    set_m = set_we ? wbits : '0;
    clr_m = clr_we ? wbits : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) en_o <= '0;
    else     en_o <= (en_o | set_m) & ~clr_m;
  end
endmodule

// File: rtl/ictl_summary.sv
module ictl_summary
  import ictl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [LOCAL_N-1:0] loc_pend,
  input  logic [BANK_N-1:0]  b1_pend,
  input  logic [BANK_N-1:0]  b2_pend,
  output logic [DATA_W-1:0]  summary
);
  localparam logic [BANK_N-1:0] M1 = sc1_mask();
  localparam logic [BANK_N-1:0] M2 = sc2_mask();

  logic [SC1_N-1:0] sc1;
  logic [SC2_N-1:0] sc2;

  for (genvar i = 0; i < SC1_N; i++) begin : g_sc1
    assign sc1[i] = b1_pend[SC1_IDX[i]];
  end
  for (genvar i = 0; i < SC2_N; i++) begin : g_sc2
    assign sc2[i] = b2_pend[SC2_IDX[i]];
  end

  always_comb begin
    summary = '0;
    summary[LOCAL_N-1:0]              = loc_pend;
    summary[FLAG1_BIT]                = |(b1_pend & ~M1);
    summary[FLAG2_BIT]                = |(b2_pend & ~M2);
    summary[SC1_BASE +: SC1_N]        = sc1;
    summary[SC2_BASE +: SC2_N]        = sc2;
  end
endmodule

// File: rtl/ictl_rdmux.sv
module ictl_rdmux
  import ictl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] summary,
  input  logic [N_SRC-1:0]  pend_all,
  input  logic [N_SRC-1:0]  en_all,
  input  logic [DATA_W-1:0] fctl,
  output logic [DATA_W-1:0] rd_next
);
  localparam int L1 = grp_lo(1);
  localparam int L2 = grp_lo(2);

  always_comb begin
    rd_next = '0;
    case (addr)
      ADDR_W'(OFS_SUM):  rd_next = summary;
      ADDR_W'(OFS_P1):   rd_next = DATA_W'(pend_all[L1 +: BANK_N]);
      ADDR_W'(OFS_P2):   rd_next = DATA_W'(pend_all[L2 +: BANK_N]);
      ADDR_W'(OFS_FCTL): rd_next = fctl;
      ADDR_W'(OFS_SET1),
      ADDR_W'(OFS_CLR1): rd_next = DATA_W'(en_all[L1 +: BANK_N]);
      ADDR_W'(OFS_SET2),
      ADDR_W'(OFS_CLR2): rd_next = DATA_W'(en_all[L2 +: BANK_N]);
      ADDR_W'(OFS_SETL),
      ADDR_W'(OFS_CLRL): rd_next = DATA_W'(en_all[0 +: LOCAL_N]);
      default:           rd_next = '0;
    endcase
  end
endmodule

// File: rtl/ictl_top.sv
module ictl_top
  import ictl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_SRC-1:0]  src_i,
  output logic              irq_o
);
  localparam int L1 = grp_lo(1);
  localparam int L2 = grp_lo(2);

  logic [N_SRC-1:0]  en_all;
  logic [N_SRC-1:0]  pend_all;
  logic [N_GRP-1:0]  set_we;
  logic [N_GRP-1:0]  clr_we;
  logic [DATA_W-1:0] fctl;
  logic [DATA_W-1:0] summary;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    set_we[0] = wr_en && (addr == ADDR_W'(OFS_SETL));
    set_we[1] = wr_en && (addr == ADDR_W'(OFS_SET1));
    set_we[2] = wr_en && (addr == ADDR_W'(OFS_SET2));
    clr_we[0] = wr_en && (addr == ADDR_W'(OFS_CLRL));
    clr_we[1] = wr_en && (addr == ADDR_W'(OFS_CLR1));
    clr_we[2] = wr_en && (addr == ADDR_W'(OFS_CLR2));
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int LO = grp_lo(g);
    localparam int GW = grp_w(g);
    ictl_enable_grp #(.W(GW)) u_en (
      .clk    (clk),
      .rst    (rst),
      .set_we (set_we[g]),
      .clr_we (clr_we[g]),
      .wbits  (wdata[GW-1:0]),
      .en_o   (en_all[LO +: GW])
    );
  end

  assign pend_all = src_i & en_all;

  ictl_summary #(.DATA_W(DATA_W)) u_sum (
    .loc_pend (pend_all[0 +: LOCAL_N]),
    .b1_pend  (pend_all[L1 +: BANK_N]),
    .b2_pend  (pend_all[L2 +: BANK_N]),
    .summary  (summary)
  );

  ictl_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .addr     (addr),
    .summary  (summary),
    .pend_all (pend_all),
    .en_all   (en_all),
    .fctl     (fctl),
    .rd_next  (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fctl  <= '0;
      rdata <= '0;
      irq_o <= 1'b0;
    end else begin
      if (wr_en && addr == ADDR_W'(OFS_FCTL)) fctl <= wdata;
      rdata <= rd_next;
      irq_o <= |pend_all;
    end
  end
endmodule

// File: rtl/ictl_checker.sv
module ictl_checker
  import ictl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [N_SRC-1:0]  src_i,
  input logic [N_SRC-1:0]  en_all,
  input logic              irq_o
);
  localparam int L1 = grp_lo(1);

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && rdata == '0 && en_all == '0));

  a_r2_set_bank1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFS_SET1)) |=>
      ((en_all[L1 +: BANK_N] & $past(wdata[BANK_N-1:0])) == $past(wdata[BANK_N-1:0])));

  a_r3_clr_bank1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFS_CLR1)) |=>
      ((en_all[L1 +: BANK_N] & $past(wdata[BANK_N-1:0])) == '0));

  a_r11_enables_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(en_all));

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(OFS_SUM)) |=> (rdata[DATA_W-1:SUM_USED] == '0));

  a_r10_irq_needs_source: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(src_i != '0));
endmodule

bind ictl_top ictl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .addr   (addr),
  .wr_en  (wr_en),
  .wdata  (wdata),
  .rdata  (rdata),
  .src_i  (src_i),
  .en_all (en_all),
  .irq_o  (irq_o)
);

// File: tb/ictl_top_bench.sv
module ictl_top_bench;
  localparam int NS = 72;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NS-1:0] src = '0;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  logic [NS-1:0] en_m = '0;
  logic [31:0]   fctl_m = '0;
  logic [31:0]   seed = 32'h1ACE_B00C;

  ictl_top u_ictl_top (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .src_i(src), .irq_o(irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  // expected summary from the bit lists in R5..R8
  function automatic logic [31:0] exp_sum(input logic [NS-1:0] p);
    logic [31:0] b1, b2, s;
    int l1 [5] = '{7, 9, 10, 18, 19};
    int l2 [6] = '{21, 22, 23, 24, 25, 30};
    b1 = p[39:8];
    b2 = p[71:40];
    s = {24'b0, p[7:0]};
    for (int i = 0; i < 5; i++) begin s[10+i] = b1[l1[i]]; b1[l1[i]] = 1'b0; end
    for (int i = 0; i < 6; i++) begin s[15+i] = b2[l2[i]]; b2[l2[i]] = 1'b0; end
    s[8] = (b1 != 0);
    s[9] = (b2 != 0);
    return s;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      8'h18: en_m[7:0]   = en_m[7:0] | d[7:0];
      8'h10: en_m[39:8]  = en_m[39:8] | d;
      8'h14: en_m[71:40] = en_m[71:40] | d;
      8'h24: en_m[7:0]   = en_m[7:0] & ~d[7:0];
      8'h1C: en_m[39:8]  = en_m[39:8] & ~d;
      8'h20: en_m[71:40] = en_m[71:40] & ~d;
      8'h0C: fctl_m = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  // full comparison of pending, summary, enable masks and request line
  task automatic check_all(input string ctx);
    logic [31:0] d;
    logic [NS-1:0] p;
    p = src & en_m;
    rd(8'h00, d); check({ctx, " R5 R6 R7 R8 summary"}, d, exp_sum(p));
    check({ctx, " R10 irq"}, {31'b0, irq}, {31'b0, (p != 0)});
    rd(8'h04, d); check({ctx, " R4 bank1 pending"}, d, p[39:8]);
    rd(8'h08, d); check({ctx, " R4 bank2 pending"}, d, p[71:40]);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h18, d); check("R1 local enables", d, 32'h0);
    rd(8'h10, d); check("R1 bank1 enables", d, 32'h0);
    rd(8'h14, d); check("R1 bank2 enables", d, 32'h0);
    rd(8'h0C, d); check("R1 fast control", d, 32'h0);
    rd(8'h00, d); check("R1 summary", d, 32'h0);

    // R12 unmapped and R11 control readback
    rd(8'h28, d); check("R12 unmapped read", d, 32'h0);
    wr(8'h0C, 32'hA5C3_0F1E);
    rd(8'h0C, d); check("R11 fast control readback", d, 32'hA5C3_0F1E);

    // R2/R9: partial set, then readback through set and clear addresses
    wr(8'h10, 32'h0000_F00F);
    wr(8'h10, 32'h0F00_0000);
    rd(8'h10, d); check("R2 R9 bank1 set readback", d, 32'h0F00_F00F);
    rd(8'h1C, d); check("R9 bank1 clear addr readback", d, 32'h0F00_F00F);
    // R3 partial clear
    wr(8'h1C, 32'h0000_0003);
    rd(8'h10, d); check("R3 bank1 partial clear", d, 32'h0F00_F00C);
    wr(8'h18, 32'hFFFF_FF81);
    rd(8'h24, d); check("R9 local zero-extended", d, 32'h0000_0081);

    // R11 writes to read-only addresses leave enables alone
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0000_0000);
    rd(8'h10, d); check("R11 bank1 enables after ro writes", d, 32'h0F00_F00C);
    rd(8'h18, d); check("R11 local enables after ro writes", d, 32'h0000_0081);

    // sweep 1: all enabled, each source alone
    wr(8'h18, 32'hFF); wr(8'h10, '1); wr(8'h14, '1);
    for (int i = 0; i < NS; i++) begin
      @(negedge clk); src = '0; src[i] = 1'b1;
      check_all($sformatf("sweep-on src %0d", i));
    end

    // R4 level: dropping the input clears pending without any write
    @(negedge clk); src = '0;
    check_all("R4 level drop");

    // sweep 2: source high, own enable cleared
    for (int i = 0; i < NS; i++) begin
      logic [31:0] m;
      m = 32'h1 << (i < 8 ? i : (i < 40 ? i - 8 : i - 40));
      @(negedge clk); src = '0; src[i] = 1'b1;
      wr(i < 8 ? 8'h24 : (i < 40 ? 8'h1C : 8'h20), m);
      check_all($sformatf("R3 sweep-off src %0d", i));
      wr(i < 8 ? 8'h18 : (i < 40 ? 8'h10 : 8'h14), m);
    end

    // mixed patterns: shortcut-only bank content vs other content (R7)
    @(negedge clk);
    src = '0; src[8+7] = 1'b1; src[40+30] = 1'b1;
    check_all("R7 shortcut only");
    @(negedge clk); src[8+8] = 1'b1;
    check_all("R7 shortcut plus plain");

    // pseudo-random mixes
    for (int k = 0; k < 60; k++) begin
      logic [31:0] r;
      r = rnd();
      @(negedge clk); src = {rnd()[7:0], rnd(), rnd()};
      case (r[2:0])
        3'd0: wr(8'h10, rnd());
        3'd1: wr(8'h1C, rnd());
        3'd2: wr(8'h14, rnd());
        3'd3: wr(8'h20, rnd());
        3'd4: wr(8'h18, rnd());
        3'd5: wr(8'h24, rnd());
        default: wr(8'h0C, rnd());
      endcase
      check_all($sformatf("random %0d", k));
      rd(8'h14, d); check("R9 bank2 mask random", d, en_m[71:40]);
      rd(8'h0C, d); check("R11 control random", d, fctl_m);
    end

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    en_m = '0; fctl_m = '0;
    check("R1 irq after second reset", {31'b0, irq}, 32'h0);
    rd(8'h14, d); check("R1 bank2 enables after second reset", d, 32'h0);
    rd(8'h0C, d); check("R1 fast control after second reset", d, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule